// File: doc/BRIEF.md
# Channel Status Byte Access Port

This block sits between a byte-wide control bus and the two 192-bit channel status stores that feed a digital audio transmitter. One store belongs to channel A and one to channel B. The bus side loads a byte pointer, then issues write or read strobes. The pointer steps forward by itself after each completed access, so a run of consecutive bytes needs only one address load. The transmitter side has a separate bit-indexed read port that returns one status bit per channel.

The port has two access modes. In single-channel mode the pointer covers 48 byte slots: the lower half addresses channel A and the upper half addresses channel B. In paired mode the pointer covers 24 byte slots, and each slot is accessed twice in a row, first for A and then for B. The pointer only moves on after the B access.

A write changes a store only when the master clock is reported present and the device is out of power-down. Otherwise the write is discarded without any error, but the pointer still advances as if the byte had been taken. Read data is registered and is marked by a one-cycle valid pulse.

Top module: `csbPort`

## Requirements
- R1: After reset, rdData is 0x00, rdValid is low, the pointer is 0, and every status bit on the transmitter port reads 0.
- R2: In single-channel mode (pairMode=0), pointer values 0..23 address channel A bytes 0..23, and pointer values 24..47 address channel B bytes 0..23. A read returns the byte last written to that slot.
- R3: In single-channel mode, the pointer increments by one after every write or read, and wraps from 47 to 0.
- R4: In paired mode (pairMode=1), two consecutive reads at one pointer value return the channel A byte first and then the channel B byte. The pointer increments after the B byte and wraps from 23 to 0.
- R5: In paired mode, the first written byte goes to channel A and the second goes to channel B, both at the same byte index.
- R6: A write with powerDown=1 or clkPresent=0 leaves both stores unchanged. The pointer still advances.
- R7: txBitA and txBitB give bit (txIdx mod 8) of byte (txIdx div 8) of their channel. txIdx=0 is bit 0 of byte 0, the first bit sent in a block. Any txIdx of 192 or more returns 0.
- R8: addrLoad sets the pointer to addrIn and restarts the paired sequence at channel A. An addrIn above 47 (single-channel mode) or above 23 (paired mode) loads 0.
- R9: rdValid is high for exactly the cycle after an accepted read strobe. rdData changes only at that point and holds until the next accepted read.
- R10: When wrStb and rdStb are high together, only the write is performed and no read data is produced. When addrLoad is high, any wrStb or rdStb in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pairMode | input | 1 | 1 = paired A/B byte mode, 0 = single-channel mode |
| addrLoad | input | 1 | Load the byte pointer from addrIn |
| addrIn | input | 6 | Byte pointer value to load |
| wrStb | input | 1 | Write one byte at the pointer |
| wrData | input | 8 | Byte to write |
| rdStb | input | 1 | Read one byte at the pointer |
| powerDown | input | 1 | Device is in power-down; writes are dropped |
| clkPresent | input | 1 | Master clock detected; writes are dropped when low |
| txIdx | input | 8 | Bit index requested by the transmitter |
| rdData | output | 8 | Registered read byte |
| rdValid | output | 1 | rdData was updated at the last edge |
| txBitA | output | 1 | Channel A status bit at txIdx |
| txBitB | output | 1 | Channel B status bit at txIdx |

## Verification
The mapping is tested by writing distinct bytes through one mode and reading them back through the other mode. This separates the A/B selection, the byte index and the order of the pair. Runs that cross the pointer wrap points (47 to 0 in single-channel mode, 23 to 0 in paired mode) show whether the wrap value and the wrap condition are right. Writes made in each blocked state are followed by reads of both the blocked slot and the next slot, which shows that the store is protected while the pointer still moves. Transmitter bit reads at indices 0, 190, 191 and beyond 191 check the bit order and the out-of-range guard.

// File: rtl/csb_pkg.sv
package csb_pkg;
  parameter int CS_BITS  = 192;
  localparam int CS_BYTES = CS_BITS / 8;
  localparam int ADDR_W   = $clog2(2 * CS_BYTES);
  localparam int IDX_W    = $clog2(CS_BYTES);
  localparam int TXI_W    = $clog2(CS_BITS);
  localparam int NCH      = 2;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic             chanB;
    logic [IDX_W-1:0] byteIdx;
  } csbStb_t;
endpackage

// File: rtl/csbCtrl.sv
module csbCtrl
  import csb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pairMode,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic              powerDown,
  input  logic              clkPresent,
  output csbStb_t           stb
);
  localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(CS_BYTES);
  localparam logic [ADDR_W-1:0] LAST_ONE  = ADDR_W'(2 * CS_BYTES - 1);
  localparam logic [ADDR_W-1:0] LAST_PAIR = ADDR_W'(CS_BYTES - 1);

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] localIdx;
  logic [ADDR_W-1:0] loadVal;
  logic              phaseB;
  logic              inUpper;
  logic              access;

  always_comb begin
    access      = (wrStb | rdStb) & ~addrLoad;
    inUpper     = (ptr >= SPAN);
    localIdx    = inUpper ? (ptr - SPAN) : ptr;
    stb.byteIdx = localIdx[IDX_W-1:0];
    stb.chanB   = pairMode ? phaseB : inUpper;
    stb.wrEn    = access & wrStb & clkPresent & ~powerDown;
    stb.rdEn    = access & rdStb & ~wrStb;
    loadVal     = (addrIn > (pairMode ? LAST_PAIR : LAST_ONE)) ? '0 : addrIn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      phaseB <= 1'b0;
    end else if (addrLoad) begin
      ptr    <= loadVal;
      phaseB <= 1'b0;
    end else if (access) begin
      if (pairMode) begin
        if (!phaseB) begin
          phaseB <= 1'b1;
        end else begin
          phaseB <= 1'b0;
          ptr    <= (ptr >= LAST_PAIR) ? '0 : ptr + 1'b1;
        end
      end else begin
        phaseB <= 1'b0;
        ptr    <= (ptr == LAST_ONE) ? '0 : ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csbData.sv
module csbData
  import csb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  csbStb_t          stb,
  input  logic [7:0]       wrData,
  input  logic [TXI_W-1:0] txIdx,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             txBitA,
  output logic             txBitB
);
  logic [7:0] store [NCH][CS_BYTES];
  logic [NCH-1:0] txBits;
  logic           txInRange;
  logic [TXI_W-4:0] txByte;
  logic [2:0]       txBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int b = 0; b < CS_BYTES; b++)
          store[c][b] <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.wrEn)
        store[stb.chanB][stb.byteIdx] <= wrData;
      rdValid <= stb.rdEn;
      if (stb.rdEn)
        rdData <= store[stb.chanB][stb.byteIdx];
    end
  end

  always_comb begin
    txInRange = (txIdx < TXI_W'(CS_BITS));
    txByte    = txIdx[TXI_W-1:3];
    txBit     = txIdx[2:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_tx
    always_comb
      txBits[ch] = txInRange ? store[ch][txByte][txBit] : 1'b0;
  end

  assign txBitA = txBits[0];
  assign txBitB = txBits[1];
endmodule

// File: rtl/csbPort.sv
module csbPort
  import csb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pairMode,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              wrStb,
  input  logic [7:0]        wrData,
  input  logic              rdStb,
  input  logic              powerDown,
  input  logic              clkPresent,
  input  logic [TXI_W-1:0]  txIdx,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              txBitA,
  output logic              txBitB
);
  csbStb_t stb;

  csbCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pairMode(pairMode), .addrLoad(addrLoad),
    .addrIn(addrIn), .wrStb(wrStb), .rdStb(rdStb), .powerDown(powerDown),
    .clkPresent(clkPresent), .stb(stb)
  );

  csbData u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData), .txIdx(txIdx),
    .rdData(rdData), .rdValid(rdValid), .txBitA(txBitA), .txBitB(txBitB)
  );
endmodule

// File: rtl/csbPort_chk.sv
module csbPort_chk
  import csb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             addrLoad,
  input logic             wrStb,
  input logic             rdStb,
  input logic             powerDown,
  input logic             clkPresent,
  input logic [TXI_W-1:0] txIdx,
  input logic [7:0]       rdData,
  input logic             rdValid,
  input logic             txBitA,
  input logic             txBitB,
  input logic             stbWr,
  input logic             stbRd
);
  // R9: an accepted read yields valid data on the next cycle
  a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && !wrStb && !addrLoad) |=> rdValid);

  // R9: read data holds whenever no new read completed
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |-> $stable(rdData));

  // R10: a write strobe never produces read data
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wrStb |=> !rdValid);

  // R10: an address load swallows both access strobes
  a_r10_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    addrLoad |-> (!stbWr && !stbRd));

  // R6: no store update is issued while the device is not ready
  a_r6_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
    (powerDown || !clkPresent) |-> !stbWr);

  // R7: indices past the block length read as zero
  a_r7_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (txIdx >= TXI_W'(CS_BITS)) |-> (!txBitA && !txBitB));
endmodule

bind csbPort csbPort_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addrLoad(addrLoad), .wrStb(wrStb), .rdStb(rdStb),
  .powerDown(powerDown), .clkPresent(clkPresent), .txIdx(txIdx),
  .rdData(rdData), .rdValid(rdValid), .txBitA(txBitA), .txBitB(txBitB),
  .stbWr(stb.wrEn), .stbRd(stb.rdEn)
);

// File: tb/csbPort_bench.sv
module csbPort_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pairMode = 1'b0, addrLoad = 1'b0, wrStb = 1'b0, rdStb = 1'b0;
  logic       powerDown = 1'b0, clkPresent = 1'b1;
  logic [5:0] addrIn = '0;
  logic [7:0] wrData = '0;
  logic [7:0] txIdx = '0;
  logic [7:0] rdData;
  logic       rdValid, txBitA, txBitB;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csbPort u_csbPort (
    .clk(clk), .rst_n(rst_n), .pairMode(pairMode), .addrLoad(addrLoad),
    .addrIn(addrIn), .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb),
    .powerDown(powerDown), .clkPresent(clkPresent), .txIdx(txIdx),
    .rdData(rdData), .rdValid(rdValid), .txBitA(txBitA), .txBitB(txBitB)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setAddr(logic [5:0] a);
    @(negedge clk); addrLoad = 1'b1; addrIn = a;
    @(negedge clk); addrLoad = 1'b0;
  endtask

  task automatic wrByte(logic [7:0] d);
    @(negedge clk); wrStb = 1'b1; wrData = d;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic rdExpect(string req, logic [7:0] exp);
    @(negedge clk); rdStb = 1'b1;
    @(negedge clk); rdStb = 1'b0;
    chk(req, {rdValid, rdData}, {1'b1, exp});
  endtask

  task automatic txExpect(string req, logic [7:0] idx, logic a, logic b);
    @(negedge clk); txIdx = idx; #1;
    chk(req, {txBitA, txBitB}, {a, b});
  endtask

  task automatic t_reset;
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 rdValid", rdValid, 1'b0);
    txExpect("R1 tx0", 8'd0, 1'b0, 1'b0);
    txExpect("R1 tx100", 8'd100, 1'b0, 1'b0);
    rdExpect("R1 pointer zero", 8'h00);
  endtask

  task automatic t_single;
    pairMode = 1'b0;
    setAddr(6'd0); wrByte(8'h11); wrByte(8'h22);
    setAddr(6'd24); wrByte(8'h33);
    setAddr(6'd0); rdExpect("R2 A0", 8'h11); rdExpect("R3 A1", 8'h22);
    setAddr(6'd24); rdExpect("R2 B0", 8'h33);
    txExpect("R7 A bit0", 8'd0, 1'b1, 1'b1);
    txExpect("R7 bit1", 8'd1, 1'b0, 1'b1);
    txExpect("R7 bit2", 8'd2, 1'b0, 1'b0);
    txExpect("R7 A bit4", 8'd4, 1'b1, 1'b1);
  endtask

  task automatic t_wrapSingle;
    pairMode = 1'b0;
    setAddr(6'd46); wrByte(8'hA5); wrByte(8'h5A); wrByte(8'hC3);
    setAddr(6'd46);
    rdExpect("R3 B22", 8'hA5); rdExpect("R3 B23", 8'h5A); rdExpect("R3 wrap A0", 8'hC3);
    txExpect("R7 idx191", 8'd191, 1'b0, 1'b0);
    txExpect("R7 idx190", 8'd190, 1'b0, 1'b1);
    txExpect("R7 idx200", 8'd200, 1'b0, 1'b0);
  endtask

  task automatic t_pair;
    pairMode = 1'b1;
    setAddr(6'd5); wrByte(8'h01); wrByte(8'h02); wrByte(8'h03); wrByte(8'h04);
    pairMode = 1'b0;
    setAddr(6'd5);  rdExpect("R5 A5", 8'h01);
    setAddr(6'd29); rdExpect("R5 B5", 8'h02);
    setAddr(6'd6);  rdExpect("R5 A6", 8'h03);
    setAddr(6'd30); rdExpect("R5 B6", 8'h04);
    pairMode = 1'b1;
    setAddr(6'd5);
    rdExpect("R4 A5", 8'h01); rdExpect("R4 B5", 8'h02);
    rdExpect("R4 A6", 8'h03); rdExpect("R4 B6", 8'h04);
    setAddr(6'd23); wrByte(8'hE1); wrByte(8'hE2); wrByte(8'hE3);
    setAddr(6'd23);
    rdExpect("R4 A23", 8'hE1); rdExpect("R4 B23", 8'hE2);
    rdExpect("R4 wrap A0", 8'hE3); rdExpect("R4 wrap B0", 8'h33);
  endtask

  task automatic t_gate;
    pairMode = 1'b0;
    setAddr(6'd10);
    powerDown = 1'b1; wrByte(8'hFF); powerDown = 1'b0;
    wrByte(8'h77);
    clkPresent = 1'b0; wrByte(8'hEE); clkPresent = 1'b1;
    setAddr(6'd10);
    rdExpect("R6 powerDown dropped", 8'h00);
    rdExpect("R6 pointer advanced", 8'h77);
    rdExpect("R6 no clock dropped", 8'h00);
  endtask

  task automatic t_load;
    pairMode = 1'b0;
    setAddr(6'd50); rdExpect("R8 range one-byte", 8'hE3);
    pairMode = 1'b1;
    setAddr(6'd30); rdExpect("R8 range pair A", 8'hE3); rdExpect("R8 range pair B", 8'h33);
    setAddr(6'd3); rdExpect("R8 A3", 8'h00);
    setAddr(6'd5); rdExpect("R8 phase restart", 8'h01);
    pairMode = 1'b0;
  endtask

  task automatic t_hold;
    setAddr(6'd0); rdExpect("R9 read", 8'hE3);
    @(negedge clk);
    chk("R9 valid one cycle", rdValid, 1'b0);
    chk("R9 data held", rdData, 8'hE3);
  endtask

  task automatic t_collide;
    pairMode = 1'b0;
    setAddr(6'd13);
    @(negedge clk); wrStb = 1'b1; rdStb = 1'b1; wrData = 8'h99;
    @(negedge clk); wrStb = 1'b0; rdStb = 1'b0;
    chk("R10 no read on write", rdValid, 1'b0);
    @(negedge clk); addrLoad = 1'b1; addrIn = 6'd14; wrStb = 1'b1; wrData = 8'h88;
    @(negedge clk); addrLoad = 1'b0; wrStb = 1'b0;
    wrByte(8'h66);
    setAddr(6'd13);
    rdExpect("R10 write performed", 8'h99);
    rdExpect("R10 load wins", 8'h66);
    rdExpect("R10 next untouched", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_single;
    t_wrapSingle;
    t_pair;
    t_gate;
    t_load;
    t_hold;
    t_collide;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule